// File: doc/BRIEF.md
# Stream Fill Beat Generator

This block clears or fills a downstream memory by sending it a programmed number of identical wide beats. Software writes a beat count into the block's only 32-bit register. While that count is non-zero, the block offers a 128-bit beat on a valid/ready stream master port. The beat is four 32-bit words, and each word is the constant 0xDEADBEEF. Each beat the sink accepts lowers the count by one. The stream stops when the count reaches zero.

The count register is live. Software can read it back at any time to see how many beats are still to go. A new write replaces whatever count remains. The count changes only on accepted beats, so a sink that holds ready low stalls the stream for as long as it likes without losing a beat. The register port is a plain 32-bit bus with byte enables. Only full-word accesses at offset 0 reach the register.

Top module: `fill_stream_gen`

## Requirements
- R1: Reset (active-low, synchronous) clears the beat count to zero. While the count is zero after reset, tx_valid stays low and a read of offset 0 returns 0.
- R2: tx_valid is high exactly while the remaining count is non-zero. After a write of N beats the block sends exactly N beats, and a write of zero sends none.
- R3: Every offered beat has tx_data equal to four copies of 32'hDEADBEEF. Word k occupies bits 32*k+31 down to 32*k.
- R4: The count falls by exactly one on each cycle with tx_valid and tx_ready both high. With tx_ready low the count, tx_valid, tx_data and tx_last all hold.
- R5: tx_last is high on the offered beat only when the count is 1, which makes it the final beat of the run.
- R6: A write at offset 0 with all four byte enables set loads the count from the write data. A write during a run replaces the remaining count.
- R7: When a loading write and an accepted beat fall in the same cycle, the count takes the written value and the decrement is dropped.
- R8: A full-word read at offset 0 returns the current remaining count, little-endian: byte enable bit 0 and byte 0 map to bits 7:0.
- R9: A read at any non-zero offset returns 0, and a write at any non-zero offset leaves the count unchanged.
- R10: An access with any byte enable cleared is invalid. Such a write leaves the count unchanged, and such a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the block |
| bus_be | input | 4 | Byte enables, all four set for a valid access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational during a read |
| tx_valid | output | 1 | Beat offered |
| tx_ready | input | 1 | Sink accepts the beat |
| tx_data | output | 128 | Fill beat |
| tx_last | output | 1 | Final beat of the run |

## Verification
The bench drives the stream through several ready patterns. It checks that the number of accepted beats equals the programmed count, and a design that decremented on offer instead of on accept would send too few beats under backpressure. It aims a write at the exact cycle a beat is accepted. A design that let the decrement win would read back one less than was written. It also sends writes and reads that are out of window or have partial byte enables. A decode that ignored the offset or the byte enables would corrupt the count or leak it on reads. A zero-count write and a one-beat run cover the ends of the range, where a faulty tx_last or tx_valid would show up first.

// File: rtl/fsg_pkg.sv
// Shared constants for the stream fill generator.
// Assumes a 32-bit register bus and a beat of whole 32-bit words.
package fsg_pkg;
    localparam int unsigned REG_W      = 32;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned BEAT_WORDS = 4;
    localparam logic [WORD_W-1:0] FILL_WORD = 32'hDEAD_BEEF;
endpackage

// File: rtl/fsg_reg_if.sv
// Register decode for the single count register at offset 0.
// Assumes full-word accesses only; anything else is treated as invalid.
module fsg_reg_if #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned REG_W  = 32,
    localparam int unsigned BE_W  = REG_W / 8
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic [REG_W-1:0]  cur_count,
    output logic              load_en,
    output logic [REG_W-1:0]  load_val,
    output logic [REG_W-1:0]  bus_rdata
);
    logic hit;

    // Decide whether the access targets the count register as a full word
    always_comb begin
        hit = bus_sel && (bus_addr == '0) && (bus_be == {BE_W{1'b1}});
    end

    // Produce the load strobe and the read data
    always_comb begin
        load_en   = hit && bus_wr;
        load_val  = bus_wdata;
        bus_rdata = (hit && !bus_wr) ? cur_count : '0;
    end
endmodule

// File: rtl/fsg_beat_counter.sv
// Remaining-beat counter. A load from the bus takes priority over the
// decrement on an accepted beat. Assumes a synchronous active-low reset.
module fsg_beat_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             accept,
    output logic [CNT_W-1:0] count,
    output logic             busy,
    output logic             final_beat
);
    // Hold the remaining count: reset, load, or step down on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load_en) begin
            count <= load_val;
        end else if (accept && busy) begin
            count <= count - CNT_W'(1);
        end
    end

    // Derive the offer and final-beat flags from the count
    always_comb begin
        busy       = (count != '0);
        final_beat = (count == CNT_W'(1));
    end
endmodule

// File: rtl/fsg_beat_data.sv
// Builds the constant fill beat from repeated copies of one word.
// Assumes the beat is a whole number of words.
module fsg_beat_data #(
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned BEAT_WORDS = 4,
    parameter logic [WORD_W-1:0] FILL = '0,
    localparam int unsigned BEAT_W    = WORD_W * BEAT_WORDS
) (
    output logic [BEAT_W-1:0] beat
);
    for (genvar w = 0; w < BEAT_WORDS; w++) begin : g_word
        // Place one copy of the fill word in lane w
        always_comb begin
            beat[w*WORD_W +: WORD_W] = FILL;
        end
    end
endmodule

// File: rtl/fill_stream_gen.sv
// Top of the stream fill generator: a register bus loads a beat count and
// the stream port sends that many constant beats, one per accepted handshake.
// Assumes a single clock domain and a synchronous active-low reset.
module fill_stream_gen
    import fsg_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    localparam int unsigned BE_W   = REG_W / 8,
    localparam int unsigned BEAT_W = WORD_W * BEAT_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [BEAT_W-1:0] tx_data,
    output logic              tx_last
);
    logic             load_en;
    logic [REG_W-1:0] load_val;
    logic [REG_W-1:0] cnt;

    fsg_reg_if #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_reg (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .cur_count (cnt),
        .load_en   (load_en),
        .load_val  (load_val),
        .bus_rdata (bus_rdata)
    );

    fsg_beat_counter #(.CNT_W(REG_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .load_val   (load_val),
        .accept     (tx_ready),
        .count      (cnt),
        .busy       (tx_valid),
        .final_beat (tx_last)
    );

    fsg_beat_data #(.WORD_W(WORD_W), .BEAT_WORDS(BEAT_WORDS), .FILL(FILL_WORD)) u_data (
        .beat (tx_data)
    );
endmodule

// File: rtl/fsg_checker.sv
// Property checker for fill_stream_gen, attached by bind.
// Relates the bus, the stream port and the internal count over time.
module fsg_checker #(
    parameter int unsigned ADDR_W = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]    bus_be,
    input logic [31:0]   bus_wdata,
    input logic [31:0]   bus_rdata,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [127:0]  tx_data,
    input logic          tx_last,
    input logic [31:0]   cnt
);
    logic wr_hit;
    assign wr_hit = bus_sel && bus_wr && (bus_addr == '0) && (bus_be == 4'hF);

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !wr_hit) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !wr_hit) |=> (cnt == $past(cnt) - 32'd1));

    // R7
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (cnt == $past(bus_wdata)));

    // R2
    idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_valid && !wr_hit) |=> !tx_valid);

    // R5
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last && !wr_hit) |=> !tx_valid);

    // R3
    fill_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_data == {4{32'hDEAD_BEEF}}));

    // R9
    window_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (bus_addr != '0)) |-> (bus_rdata == 32'd0));

    // R10
    partial_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && (bus_be != 4'hF) && !(tx_valid && tx_ready)) |=> $stable(cnt));
endmodule

bind fill_stream_gen fsg_checker #(.ADDR_W(ADDR_W)) u_fsg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .cnt       (cnt)
);

// File: tb/test_fill_stream_gen.sv
module test_fill_stream_gen;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [3:0]   bus_be = 4'h0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         tx_valid;
    logic         tx_ready = 1'b0;
    logic [127:0] tx_data;
    logic         tx_last;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam logic [127:0] FILL = {4{32'hDEAD_BEEF}};

    // vector: {beat count, 16-bit ready pattern}
    localparam int NVEC = 6;
    localparam logic [47:0] VEC [NVEC] = '{
        {32'd1,  16'hFFFF},
        {32'd3,  16'h5555},
        {32'd5,  16'hFFFF},
        {32'd0,  16'hFFFF},
        {32'd4,  16'h8421},
        {32'd7,  16'h3C3C}
    };

    fill_stream_gen i_fill_stream_gen (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_last(tx_last)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'h0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = be;
        #1 d = bus_rdata;
        bus_sel = 1'b0; bus_be = 4'h0;
    endtask

    // Drive tx_ready from a pattern and count accepted beats until tx_valid drops
    task automatic drain(input logic [15:0] pat, input int exp_n, output int got);
        got = 0;
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            tx_ready = pat[c % 16];
            #1;
            if (!tx_valid) break;
            if (tx_data != FILL) check(1'b0, "R3 beat data", tx_data, FILL);
            if (tx_ready) begin
                got++;
                check(tx_last == (got == exp_n), "R5 last flag", 128'(tx_last), 128'(got == exp_n));
            end
        end
        tx_ready = 1'b0;
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++; checks++;
                $display("FAIL watchdog expired");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin : main
        logic [31:0] rd;
        int got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk); #1;
        check(tx_valid == 1'b0, "R1 valid after reset", 128'(tx_valid), 128'd0);
        bus_read(12'h000, 4'hF, rd);
        check(rd == 32'd0, "R1 count after reset", 128'(rd), 128'd0);

        // Vector table: R2, R3, R4, R5
        for (int v = 0; v < NVEC; v++) begin
            bus_write(12'h000, VEC[v][47:16], 4'hF);
            drain(VEC[v][15:0], int'(VEC[v][47:16]), got);
            check(got == int'(VEC[v][47:16]), "R2 beats sent", 128'(got), 128'(VEC[v][47:16]));
            bus_read(12'h000, 4'hF, rd);
            check(rd == 32'd0, "R4 count at end", 128'(rd), 128'd0);
        end

        // R4: stall holds count and valid
        bus_write(12'h000, 32'd4, 4'hF);
        repeat (10) @(negedge clk);
        #1 check(tx_valid == 1'b1 && tx_data == FILL, "R4 valid held in stall", 128'(tx_valid), 128'd1);
        bus_read(12'h000, 4'hF, rd);
        check(rd == 32'd4, "R4 count held in stall", 128'(rd), 128'd4);

        // R6: replace during a run
        bus_write(12'h000, 32'd2, 4'hF);
        bus_read(12'h000, 4'hF, rd);
        check(rd == 32'd2, "R6 replaced count", 128'(rd), 128'd2);
        drain(16'hFFFF, 2, got);
        check(got == 2, "R6 beats after replace", 128'(got), 128'd2);

        // R8: live readback mid-run, little-endian
        bus_write(12'h000, 32'd6, 4'hF);
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk);
        @(negedge clk); tx_ready = 1'b0;
        bus_read(12'h000, 4'hF, rd);
        check(rd == 32'd4, "R8 live count", 128'(rd), 128'd4);
        bus_write(12'h000, 32'h0000_0102, 4'hF);
        bus_read(12'h000, 4'hF, rd);
        check(rd[7:0] == 8'h02 && rd[15:8] == 8'h01, "R8 byte order", 128'(rd), 128'h102);

        // R7: write and accept in the same cycle
        bus_write(12'h000, 32'd5, 4'hF);
        @(negedge clk);
        tx_ready = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h000; bus_be = 4'hF; bus_wdata = 32'd9;
        @(negedge clk);
        tx_ready = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'h0;
        bus_read(12'h000, 4'hF, rd);
        check(rd == 32'd9, "R7 write beats decrement", 128'(rd), 128'd9);

        // R9: out-of-window access
        bus_read(12'h004, 4'hF, rd);
        check(rd == 32'd0, "R9 read outside window", 128'(rd), 128'd0);
        bus_write(12'h004, 32'd3, 4'hF);
        bus_read(12'h000, 4'hF, rd);
        check(rd == 32'd9, "R9 write outside window", 128'(rd), 128'd9);

        // R10: partial byte enables
        bus_write(12'h000, 32'd2, 4'b0011);
        bus_read(12'h000, 4'hF, rd);
        check(rd == 32'd9, "R10 partial write ignored", 128'(rd), 128'd9);
        bus_read(12'h000, 4'b0001, rd);
        check(rd == 32'd0, "R10 partial read zero", 128'(rd), 128'd0);

        // R1: reset during a run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1 check(tx_valid == 1'b0, "R1 valid after mid-run reset", 128'(tx_valid), 128'd0);
        bus_read(12'h000, 4'hF, rd);
        check(rd == 32'd0, "R1 count after mid-run reset", 128'(rd), 128'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule